// File: doc/BRIEF.md
# Program counter with branch control

This block holds the program counter of a single-cycle processor and chooses its next value on every clock edge. Each cycle the counter does one of four things. It steps to the following word. It loads an absolute target taken from a register read port. It adds a signed, PC-relative displacement when the selected status flag is set. If that flag is clear, it falls through to the following word.

Three control bits from the instruction decoder pick the operation: a load enable, a jump/branch select and a condition select. The 6-bit displacement comes from two 3-bit fields of the instruction word that are not next to each other. The high field is placed above the low field, and the 6-bit result is sign-extended as two's complement to the counter width. The counter value drives the instruction memory address directly.

Top module: `pc_branch_unit`

## Requirements
- R1: While `rst` is 1 at a rising clock edge, `pc_q` becomes 0 after that edge, whatever the other inputs are.
- R2: When `pc_load` is 0, `pc_q` advances by exactly 1 at each edge.
- R3: When `pc_load` is 1 and `jump_sel` is 1, `pc_q` takes the value of `jump_addr` at the edge, and the flags and displacement fields have no effect.
- R4: When `pc_load` is 1, `jump_sel` is 0, `cond_sel` is 1 and `neg_flag` is 1, `pc_q` becomes the current `pc_q` plus the sign-extended displacement. The displacement is added to the current value, not to the value plus 1.
- R5: When `pc_load` is 1, `jump_sel` is 0, `cond_sel` is 0 and `zero_flag` is 1, `pc_q` becomes the current `pc_q` plus the sign-extended displacement.
- R6: A branch whose selected flag is 0 leaves `pc_q` at its current value plus 1. The flag that `cond_sel` does not select is ignored.
- R7: The displacement is the 6-bit value {`ofs_hi`, `ofs_lo`}, with `ofs_hi` in bits 5:3, read as two's complement (bit 5 is the sign). For example, with `pc_q` = 45, `ofs_hi` = 3'b110 and `ofs_lo` = 3'b100 (-12), a taken branch gives 33.
- R8: All additions wrap modulo 2^16 with no trap. Stepping from 16'hFFFF gives 0, and a negative displacement below 0 wraps to the top of the address range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| neg_flag | input | 1 | Negative status of the source register |
| zero_flag | input | 1 | Zero status of the source register |
| pc_load | input | 1 | 0 = step by one, 1 = jump or branch |
| jump_sel | input | 1 | 1 = absolute jump, 0 = conditional branch |
| cond_sel | input | 1 | 1 = branch tests `neg_flag`, 0 = branch tests `zero_flag` |
| ofs_hi | input | 3 | Upper three bits of the displacement (sign in the top bit) |
| ofs_lo | input | 3 | Lower three bits of the displacement |
| jump_addr | input | 16 | Absolute target from the register read bus |
| pc_q | output | 16 | Current program counter, drives the instruction memory address |

## Verification
The embedded properties assume that every control, flag and displacement input holds a defined 0 or 1 at each sampling edge. They also assume that reset is applied from time zero, so the counter never starts from an unknown value. The bench meets both assumptions. It drives every input at the falling edge, starting in the first cycle with reset held high. It draws random values only from fully specified bit patterns.

The directed steps start at chosen counter values near zero and near 16'hFFFF. From there they reach the wrap points and the worked displacement example.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
   typedef enum logic [1:0] {
      NXT_SEQ  = 2'd0,
      NXT_JUMP = 2'd1,
      NXT_REL  = 2'd2
   } nxt_kind_e;
endpackage

// File: rtl/pcb_offset_ext.sv
module pcb_offset_ext #(
   parameter int HI_W = 3,
   parameter int LO_W = 3,
   parameter int PC_W = 16
) (
   input  logic [HI_W-1:0] ofs_hi,
   input  logic [LO_W-1:0] ofs_lo,
   output logic [PC_W-1:0] ofs_ext
);
   localparam int OFS_W = HI_W + LO_W;

   logic [OFS_W-1:0] raw;
   assign raw = {ofs_hi, ofs_lo};

   generate
      if (PC_W > OFS_W) begin : g_extend
         assign ofs_ext = {{(PC_W-OFS_W){raw[OFS_W-1]}}, raw};
      end else begin : g_same
         assign ofs_ext = raw[PC_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/pcb_branch_ctl.sv
module pcb_branch_ctl
   import pcb_pkg::*;
(
   input  logic      pc_load,
   input  logic      jump_sel,
   input  logic      cond_sel,
   input  logic      neg_flag,
   input  logic      zero_flag,
   output nxt_kind_e kind
);
   logic cond_hit;

   always_comb begin
      cond_hit = cond_sel ? neg_flag : zero_flag;
      if (!pc_load)
         kind = NXT_SEQ;
      else if (jump_sel)
         kind = NXT_JUMP;
      else if (cond_hit)
         kind = NXT_REL;
      else
         kind = NXT_SEQ;
   end
endmodule

// File: rtl/pcb_next_addr.sv
module pcb_next_addr
   import pcb_pkg::*;
#(
   parameter int PC_W         = 16,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic [PC_W-1:0] pc_cur,
   input  logic [PC_W-1:0] jump_addr,
   input  logic [PC_W-1:0] ofs_ext,
   input  nxt_kind_e       kind,
   output logic [PC_W-1:0] pc_nxt
);
   localparam logic [PC_W-1:0] STEP = PC_W'(1);

   generate
      if (SHARED_ADDER) begin : g_shared
         logic [PC_W-1:0] addend;
         always_comb begin
            addend = (kind == NXT_REL) ? ofs_ext : STEP;
            pc_nxt = (kind == NXT_JUMP) ? jump_addr : pc_cur + addend;
         end
      end else begin : g_dual
         logic [PC_W-1:0] seq_sum;
         logic [PC_W-1:0] rel_sum;
         always_comb begin
            seq_sum = pc_cur + STEP;
            rel_sum = pc_cur + ofs_ext;
            unique case (kind)
               NXT_JUMP: pc_nxt = jump_addr;
               NXT_REL:  pc_nxt = rel_sum;
               default:  pc_nxt = seq_sum;
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/pc_branch_unit.sv
module pc_branch_unit
   import pcb_pkg::*;
#(
   parameter int PC_W         = 16,
   parameter int HI_W         = 3,
   parameter int LO_W         = 3,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            neg_flag,
   input  logic            zero_flag,
   input  logic            pc_load,
   input  logic            jump_sel,
   input  logic            cond_sel,
   input  logic [HI_W-1:0] ofs_hi,
   input  logic [LO_W-1:0] ofs_lo,
   input  logic [PC_W-1:0] jump_addr,
   output logic [PC_W-1:0] pc_q
);
   localparam int OFS_W = HI_W + LO_W;
   localparam logic [PC_W-1:0] ONE = PC_W'(1);

   generate
      if (OFS_W > PC_W) begin : g_bad_width
         $error("displacement wider than program counter");
      end
      if (HI_W < 1 || LO_W < 1) begin : g_bad_field
         $error("displacement fields must be at least one bit");
      end
   endgenerate

   logic [PC_W-1:0] ofs_ext;
   logic [PC_W-1:0] pc_nxt;
   nxt_kind_e       kind;

   pcb_offset_ext #(.HI_W(HI_W), .LO_W(LO_W), .PC_W(PC_W)) u_ofs (
      .ofs_hi (ofs_hi),
      .ofs_lo (ofs_lo),
      .ofs_ext(ofs_ext)
   );

   pcb_branch_ctl u_ctl (
      .pc_load  (pc_load),
      .jump_sel (jump_sel),
      .cond_sel (cond_sel),
      .neg_flag (neg_flag),
      .zero_flag(zero_flag),
      .kind     (kind)
   );

   pcb_next_addr #(.PC_W(PC_W), .SHARED_ADDER(SHARED_ADDER)) u_nxt (
      .pc_cur   (pc_q),
      .jump_addr(jump_addr),
      .ofs_ext  (ofs_ext),
      .kind     (kind),
      .pc_nxt   (pc_nxt)
   );

   always_ff @(posedge clk) begin
      if (rst)
         pc_q <= '0;
      else
         pc_q <= pc_nxt;
   end

   assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> pc_q == '0);

   assert_count_up_R2: assert property (@(posedge clk) disable iff (rst)
      !pc_load |=> pc_q == $past(pc_q) + ONE);

   assert_jump_load_R3: assert property (@(posedge clk) disable iff (rst)
      (pc_load && jump_sel) |=> pc_q == $past(jump_addr));

   assert_neg_branch_R4: assert property (@(posedge clk) disable iff (rst)
      (pc_load && !jump_sel && cond_sel && neg_flag)
      |=> pc_q == $past(pc_q) + $past(ofs_ext));

   assert_zero_branch_R5: assert property (@(posedge clk) disable iff (rst)
      (pc_load && !jump_sel && !cond_sel && zero_flag)
      |=> pc_q == $past(pc_q) + $past(ofs_ext));

   assert_fall_through_R6: assert property (@(posedge clk) disable iff (rst)
      (pc_load && !jump_sel && !(cond_sel ? neg_flag : zero_flag))
      |=> pc_q == $past(pc_q) + ONE);

   assert_sign_ext_R7: assert property (@(posedge clk) disable iff (rst)
      ofs_ext[PC_W-1] == ofs_hi[HI_W-1] && ofs_ext[LO_W-1:0] == ofs_lo);

   assert_wrap_top_R8: assert property (@(posedge clk) disable iff (rst)
      (!pc_load && pc_q == '1) |=> pc_q == '0);
endmodule

// File: tb/pc_branch_unit_tb.sv
module pc_branch_unit_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        neg_flag = 1'b0, zero_flag = 1'b0;
   logic        pc_load = 1'b0, jump_sel = 1'b0, cond_sel = 1'b0;
   logic [2:0]  ofs_hi = 3'd0, ofs_lo = 3'd0;
   logic [15:0] jump_addr = 16'd0;
   logic [15:0] pc_q;

   int n_checks = 0;
   int n_fail   = 0;
   int ref_pc   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pc_branch_unit u_dut (
      .clk(clk), .rst(rst), .neg_flag(neg_flag), .zero_flag(zero_flag),
      .pc_load(pc_load), .jump_sel(jump_sel), .cond_sel(cond_sel),
      .ofs_hi(ofs_hi), .ofs_lo(ofs_lo), .jump_addr(jump_addr), .pc_q(pc_q)
   );

   task automatic step(input bit r, input bit pl, input bit jb, input bit bc,
                       input bit n, input bit z, input int hi, input int lo,
                       input int ja, input string tag_in);
      int    disp;
      int    expv;
      string tag;
      @(negedge clk);
      rst = r; pc_load = pl; jump_sel = jb; cond_sel = bc;
      neg_flag = n; zero_flag = z;
      ofs_hi = hi[2:0]; ofs_lo = lo[2:0]; jump_addr = ja[15:0];
      disp = (hi % 8) * 8 + (lo % 8);
      if (disp >= 32) disp = disp - 64;
      if (r) begin
         expv = 0; tag = "R1";
      end else if (!pl) begin
         expv = (ref_pc + 1) % 65536;
         tag = (ref_pc == 65535) ? "R8" : "R2";
      end else if (jb) begin
         expv = ja % 65536; tag = "R3";
      end else if (bc ? n : z) begin
         expv = (ref_pc + disp + 65536) % 65536;
         tag = bc ? "R4" : "R5";
      end else begin
         expv = (ref_pc + 1) % 65536; tag = "R6";
      end
      if (tag_in != "") tag = tag_in;
      @(posedge clk);
      #(CLK_PERIOD/4);
      n_checks++;
      if (int'(pc_q) != expv) begin
         n_fail++;
         $display("FAIL %s: pc_q=%0d expected=%0d", tag, pc_q, expv);
      end
      ref_pc = expv;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      // R1 reset state with noisy inputs
      step(1, 1, 1, 0, 1, 1, 5, 5, 16'h1234, "R1");
      step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
      // R2 counting
      for (int i = 0; i < 4; i++) step(0, 0, 1, 1, 1, 1, 7, 7, 16'hBEEF, "R2");
      // R3 jump ignores flags and displacement
      step(0, 1, 1, 0, 1, 0, 3, 2, 100, "R3");
      step(0, 1, 1, 1, 0, 1, 6, 1, 16'h8000, "R3");
      step(0, 1, 1, 0, 0, 0, 0, 0, 200, "R3");
      // R4 negative branch taken (+5), added to current value
      step(0, 1, 0, 1, 1, 0, 0, 5, 0, "R4");
      // R5 zero branch taken (-3)
      step(0, 1, 0, 0, 0, 1, 7, 5, 0, "R5");
      // R6 not taken, unselected flag ignored
      step(0, 1, 0, 1, 0, 1, 1, 1, 0, "R6");
      step(0, 1, 0, 0, 1, 0, 1, 1, 0, "R6");
      // R7 worked example 45 + (-12) = 33
      step(0, 1, 1, 0, 0, 0, 0, 0, 45, "R3");
      step(0, 1, 0, 0, 0, 1, 6, 4, 0, "R7");
      // R7 most negative and most positive displacement
      step(0, 1, 0, 1, 1, 0, 4, 0, 0, "R7");
      step(0, 1, 0, 1, 1, 0, 3, 7, 0, "R7");
      // R8 wrap on count and on negative branch
      step(0, 1, 1, 0, 0, 0, 0, 0, 16'hFFFF, "R3");
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
      step(0, 1, 0, 0, 0, 1, 6, 4, 0, "R8");
      step(0, 1, 1, 0, 0, 0, 0, 0, 16'hFFFE, "R3");
      step(0, 1, 0, 1, 1, 0, 0, 3, 0, "R8");
      // R1 mid-run reset
      step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
      // mixed random traffic against the reference model
      for (int i = 0; i < 400; i++) begin
         int rv;
         rv = int'($urandom);
         step((rv % 61) == 0, rv[1], rv[2] & rv[3], rv[4], rv[5], rv[6],
              (rv >> 8) % 8, (rv >> 11) % 8, (rv >> 14) % 65536, "");
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule